// File: doc/BRIEF.md
# Output-Encoded Traffic Light Controller

This block sequences the lights at a junction of a highway and a farm road. A sensor on the farm road reports a waiting car. The highway keeps green until a car is waiting and a long interval has passed. The controller then warns the highway with yellow and gives the farm road green. The farm road keeps green while cars keep coming, for at most the long interval. It then warns with yellow and gives the highway back. Both yellow phases last a short interval.

No separate state register exists. The registered light codes of the two roads form the whole state: each of the four phases drives a pattern that no other phase drives. The next-state logic is therefore written as next-output logic. Five registered bits hold all of it: two highway bits, two farm bits and a one-cycle restart pulse for the interval timer. The controller includes that timer. It counts cycles from each restart and saturates once the long interval is reached. The phases are highway go (PH_HWY_GO), highway warn (PH_HWY_WARN), farm go (PH_FARM_GO) and farm warn (PH_FARM_WARN). A fifth decode, PH_ILLEGAL, covers any other light pattern. The transitions are highway yield (go to warn), highway release (warn to farm go), farm yield (farm go to farm warn), farm release (farm warn to highway go) and recovery (illegal to highway go).

Top module: `tlc_output_encoded_ctrl`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the next edge sets the highway code to 00, the farm code to 10 and the restart pulse to 0.
- R2: Each light code uses green = 00, yellow = 01 and red = 10. The patterns as {highway, farm} are: highway go 00/10, highway warn 01/10, farm go 10/00 and farm warn 10/01.
- R3: Highway go holds while no car is present or the long timeout is low. When a car is present and the long timeout is high, the next edge enters highway warn with the restart pulse high.
- R4: Highway warn waits for the short timeout and then enters farm go with the restart pulse high. It lasts exactly SHORT_TICKS+1 cycles.
- R5: Farm go leaves on the first edge where no car is present or the long timeout is high. It enters farm warn with the restart pulse high.
- R6: Farm warn waits for the short timeout. It then returns to highway go with the restart pulse high, after exactly SHORT_TICKS+1 cycles.
- R7: The restart pulse is high for exactly the cycle that follows each phase change and is low in every other cycle.
- R8: Timeouts count from the cycle in which the restart pulse is high, which is cycle 0, or from the first cycle after reset. The short timeout is high from cycle SHORT_TICKS onward and the long timeout from cycle LONG_TICKS onward. Both stay high until the next restart.
- R9: Any pattern of the two light codes outside the four in R2 is replaced on the next edge by highway go with the restart pulse high.
- R10: Whenever one road shows green or yellow, the other road shows red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| car_present | input | 1 | Farm-road sensor, high while a car waits |
| hwy_light | output | 2 | Registered highway light code |
| farm_light | output | 2 | Registered farm-road light code |
| start_timer | output | 1 | Registered one-cycle restart of the interval timer |

## Verification
The assertions assume that car_present is synchronous to clk and stable around each rising edge. They also assume that the light registers change only through the clock, except during the one deliberate corruption used to reach the recovery path. The stimulus drives the sensor only at falling edges. It holds the sensor constant, sweeps every repeating four-cycle sensor pattern, and finishes with a pseudo-random sequence. Each assertion that reasons about light history is gated on the restart pulse or on a legal current pattern, so it stays true across the single forced illegal pattern.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef enum logic [1:0] {
        LC_GREEN  = 2'b00,
        LC_YELLOW = 2'b01,
        LC_RED    = 2'b10
    } light_e;

    typedef enum logic [2:0] {
        PH_HWY_GO,
        PH_HWY_WARN,
        PH_FARM_GO,
        PH_FARM_WARN,
        PH_ILLEGAL
    } phase_e;

    typedef struct packed {
        light_e hwy;
        light_e farm;
    } lamp_pair_t;

    // Output pattern that identifies each phase; illegal maps to highway go.
    function automatic lamp_pair_t lamps_of(phase_e ph);
        lamp_pair_t lp;
        case (ph)
            PH_HWY_WARN:  begin lp.hwy = LC_YELLOW; lp.farm = LC_RED;    end
            PH_FARM_GO:   begin lp.hwy = LC_RED;    lp.farm = LC_GREEN;  end
            PH_FARM_WARN: begin lp.hwy = LC_RED;    lp.farm = LC_YELLOW; end
            default:      begin lp.hwy = LC_GREEN;  lp.farm = LC_RED;    end
        endcase
        return lp;
    endfunction

endpackage

// File: rtl/tlc_interval_timer.sv
module tlc_interval_timer #(
    parameter int SHORT_TICKS = 4,
    parameter int LONG_TICKS  = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic short_done,
    output logic long_done
);
    localparam int CW = $clog2(LONG_TICKS + 1);
    localparam logic [CW-1:0] SH_LIM = CW'(SHORT_TICKS);
    localparam logic [CW-1:0] LG_LIM = CW'(LONG_TICKS);

    logic [CW-1:0] ticks;

    // The restart cycle itself is cycle 0, so the count resumes at 1.
    always_ff @(posedge clk) begin
        if (rst) begin
            ticks <= '0;
        end else if (restart) begin
            ticks <= CW'(1);
        end else if (ticks < LG_LIM) begin
            ticks <= ticks + 1'b1;
        end
    end

    assign short_done = !restart && (ticks >= SH_LIM);
    assign long_done  = !restart && (ticks >= LG_LIM);

    // R8
    long_before_short_chk: assert property (@(posedge clk) disable iff (rst)
        long_done |-> short_done);

    // R8
    short_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (short_done && !restart) |=> (short_done || restart));

    // R8
    restart_masks_chk: assert property (@(posedge clk) disable iff (rst)
        restart |-> (!short_done && !long_done));

endmodule

// File: rtl/tlc_phase_decode.sv
module tlc_phase_decode
    import tlc_pkg::*;
(
    input  logic [1:0] hwy_code,
    input  logic [1:0] farm_code,
    output phase_e     phase
);
    always_comb begin
        unique case ({hwy_code, farm_code})
            4'b00_10: phase = PH_HWY_GO;
            4'b01_10: phase = PH_HWY_WARN;
            4'b10_00: phase = PH_FARM_GO;
            4'b10_01: phase = PH_FARM_WARN;
            default:  phase = PH_ILLEGAL;
        endcase
    end
endmodule

// File: rtl/tlc_next_output.sv
module tlc_next_output
    import tlc_pkg::*;
(
    input  phase_e     phase,
    input  logic       car_present,
    input  logic       short_done,
    input  logic       long_done,
    output logic [1:0] nxt_hwy,
    output logic [1:0] nxt_farm,
    output logic       nxt_start
);
    phase_e     target;
    logic       move;
    lamp_pair_t lamps;

    always_comb begin
        target = phase;
        move   = 1'b0;
        unique case (phase)
            PH_HWY_GO: begin
                if (car_present && long_done) begin
                    target = PH_HWY_WARN;
                    move   = 1'b1;
                end
            end
            PH_HWY_WARN: begin
                if (short_done) begin
                    target = PH_FARM_GO;
                    move   = 1'b1;
                end
            end
            PH_FARM_GO: begin
                if (!car_present || long_done) begin
                    target = PH_FARM_WARN;
                    move   = 1'b1;
                end
            end
            PH_FARM_WARN: begin
                if (short_done) begin
                    target = PH_HWY_GO;
                    move   = 1'b1;
                end
            end
            PH_ILLEGAL: begin
                target = PH_HWY_GO;
                move   = 1'b1;
            end
            default: begin
                target = PH_HWY_GO;
                move   = 1'b1;
            end
        endcase
        lamps     = lamps_of(target);
        nxt_hwy   = lamps.hwy;
        nxt_farm  = lamps.farm;
        nxt_start = move;
    end
endmodule

// File: rtl/tlc_output_encoded_ctrl.sv
module tlc_output_encoded_ctrl
    import tlc_pkg::*;
#(
    parameter int SHORT_TICKS = 4,
    parameter int LONG_TICKS  = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       car_present,
    output logic [1:0] hwy_light,
    output logic [1:0] farm_light,
    output logic       start_timer
);
    phase_e     phase;
    logic       short_done;
    logic       long_done;
    logic [1:0] nxt_hwy;
    logic [1:0] nxt_farm;
    logic       nxt_start;

    tlc_phase_decode u_decode (
        .hwy_code  (hwy_light),
        .farm_code (farm_light),
        .phase     (phase)
    );

    tlc_interval_timer #(
        .SHORT_TICKS (SHORT_TICKS),
        .LONG_TICKS  (LONG_TICKS)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .restart    (start_timer),
        .short_done (short_done),
        .long_done  (long_done)
    );

    tlc_next_output u_next (
        .phase       (phase),
        .car_present (car_present),
        .short_done  (short_done),
        .long_done   (long_done),
        .nxt_hwy     (nxt_hwy),
        .nxt_farm    (nxt_farm),
        .nxt_start   (nxt_start)
    );

    // The five output bits are the only state of the controller.
    always_ff @(posedge clk) begin
        if (rst) begin
            hwy_light   <= LC_GREEN;
            farm_light  <= LC_RED;
            start_timer <= 1'b0;
        end else begin
            hwy_light   <= nxt_hwy;
            farm_light  <= nxt_farm;
            start_timer <= nxt_start;
        end
    end

    // R10
    hwy_shows_farm_red_chk: assert property (@(posedge clk) disable iff (rst)
        (hwy_light == LC_GREEN || hwy_light == LC_YELLOW) |-> (farm_light == LC_RED));

    // R10
    farm_shows_hwy_red_chk: assert property (@(posedge clk) disable iff (rst)
        (farm_light == LC_GREEN || farm_light == LC_YELLOW) |-> (hwy_light == LC_RED));

    // R7
    start_marks_change_chk: assert property (@(posedge clk) disable iff (rst)
        start_timer |-> (hwy_light != $past(hwy_light) || farm_light != $past(farm_light)));

    // R7
    stable_without_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!start_timer && phase != PH_ILLEGAL && $past(phase) != PH_ILLEGAL)
            |-> ($stable(hwy_light) && $stable(farm_light)));

    // R3
    hwy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HWY_GO && !(car_present && long_done)) |=> !start_timer);

    // R3
    hwy_yield_order_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == PH_HWY_GO && start_timer) |-> (phase == PH_HWY_WARN));

    // R4
    hwy_release_order_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == PH_HWY_WARN && start_timer) |-> (phase == PH_FARM_GO));

    // R5
    farm_yield_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FARM_GO && (!car_present || long_done)) |=> (phase == PH_FARM_WARN && start_timer));

    // R6
    farm_release_order_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == PH_FARM_WARN && start_timer) |-> (phase == PH_HWY_GO));

    // R9
    illegal_recover_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ILLEGAL) |=> (phase == PH_HWY_GO && start_timer));

endmodule

// File: tb/test_tlc_output_encoded_ctrl.sv
module test_tlc_output_encoded_ctrl;
    localparam int SH = 2;
    localparam int LG = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       car = 1'b0;
    logic [1:0] hwy;
    logic [1:0] farm;
    logic       st;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Bench model: phase 0..3 = highway go, highway warn, farm go, farm warn.
    int m_ph  = 0;
    int m_e   = 0;
    bit m_st  = 0;

    always #5 clk = ~clk;

    tlc_output_encoded_ctrl #(
        .SHORT_TICKS (SH),
        .LONG_TICKS  (LG)
    ) i_tlc_output_encoded_ctrl (
        .clk         (clk),
        .rst         (rst),
        .car_present (car),
        .hwy_light   (hwy),
        .farm_light  (farm),
        .start_timer (st)
    );

    // R2 patterns: green 00, yellow 01, red 10.
    function automatic logic [3:0] pattern(int ph);
        case (ph)
            0:       return 4'b00_10;
            1:       return 4'b01_10;
            2:       return 4'b10_00;
            default: return 4'b10_01;
        endcase
    endfunction

    function automatic string tag_for(int ph);
        case (ph)
            0:       return "R6";
            1:       return "R3";
            2:       return "R4";
            default: return "R5";
        endcase
    endfunction

    // R8: the timeouts are derived from cycles since the last entry.
    task automatic model_step(input bit c);
        bit sd = (m_e >= SH);
        bit ld = (m_e >= LG);
        bit mv = 0;
        int nx = m_ph;
        case (m_ph)
            0: if (c && ld)  begin mv = 1; nx = 1; end
            1: if (sd)       begin mv = 1; nx = 2; end
            2: if (!c || ld) begin mv = 1; nx = 3; end
            default: if (sd) begin mv = 1; nx = 0; end
        endcase
        if (mv) begin m_ph = nx; m_e = 0; m_st = 1; end
        else    begin m_e = m_e + 1; m_st = 0; end
    endtask

    task automatic compare(input string what);
        logic [4:0] exp_v = {pattern(m_ph), m_st};
        n_checks++;
        if ({hwy, farm, st} !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s (R2 pattern, R7 pulse, R8 timing): got %b expected %b",
                     what, tag_for(m_ph), {hwy, farm, st}, exp_v);
        end
        // R10
        n_checks++;
        if (((hwy == 2'b00 || hwy == 2'b01) && farm !== 2'b10) ||
            ((farm == 2'b00 || farm == 2'b01) && hwy !== 2'b10)) begin
            n_fail++;
            $display("FAIL R10 cross red: got hwy %b farm %b expected one road at 10", hwy, farm);
        end
    endtask

    task automatic cycle(input bit c, input string what);
        car = c;
        model_step(c);
        @(negedge clk);
        compare(what);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        car = 1'b0;
        repeat (2) @(negedge clk);
        m_ph = 0; m_e = 0; m_st = 0;
        // R1
        n_checks++;
        if ({hwy, farm, st} !== 5'b00_10_0) begin
            n_fail++;
            $display("FAIL R1 reset state: got %b expected %b", {hwy, farm, st}, 5'b00_10_0);
        end
        rst = 1'b0;
    endtask

    initial begin
        bit [7:0] lfsr = 8'hA5;
        do_reset();

        // R3: no car keeps the highway green forever
        for (int i = 0; i < 20; i++) cycle(1'b0, "no car");
        // R3 R4 R5 R6: a steady car stream rotates through all phases on the long limit
        for (int i = 0; i < 40; i++) cycle(1'b1, "steady car");

        // Sweep every repeating four-cycle sensor pattern
        for (int p = 0; p < 16; p++) begin
            do_reset();
            for (int i = 0; i < 24; i++) cycle(p[i % 4], "pattern sweep");
        end

        // Pseudo-random sensor sequence
        do_reset();
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cycle(lfsr[0], "random");
        end

        // R9: corrupt the light registers, expect highway go with a restart
        do_reset();
        for (int i = 0; i < 3; i++) cycle(1'b0, "pre corrupt");
        force i_tlc_output_encoded_ctrl.hwy_light  = 2'b11;
        force i_tlc_output_encoded_ctrl.farm_light = 2'b11;
        #1;
        release i_tlc_output_encoded_ctrl.hwy_light;
        release i_tlc_output_encoded_ctrl.farm_light;
        car = 1'b0;
        @(negedge clk);
        n_checks++;
        if ({hwy, farm, st} !== 5'b00_10_1) begin
            n_fail++;
            $display("FAIL R9 recovery: got %b expected %b", {hwy, farm, st}, 5'b00_10_1);
        end
        m_ph = 0; m_e = 0; m_st = 1;
        for (int i = 0; i < 30; i++) cycle(i[2] | i[0], "after recovery");

        // R1: reset taken in the middle of farm go
        for (int i = 0; i < 12; i++) cycle(1'b1, "pre reset");
        do_reset();
        for (int i = 0; i < 10; i++) cycle(1'b1, "post reset");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule